// File: doc/BRIEF.md
# Capability Memory-Access Check Unit

This block sits between the address stage of a load/store pipeline and memory. It takes a fat-pointer capability (validity tag, sealed flag, base, length, offset and permission bits) together with an instruction's signed immediate, its register operand, the access size and the access kind. From these it forms the effective address, decides whether the access must trap and with which cause, and works out the tag bit that goes with the access: the tag returned with a capability load, or the tag written by a capability store.

The checks are evaluated in one combinational pass and captured in a single output register stage. Each request presented with `req_valid` high yields a response one clock later. Two page-level bits from the translation stage control tag movement. A missing load-capability right never traps; it only strips the tag from the returned value. A missing store-capability right traps only when a tagged value would actually reach memory. Address arithmetic wraps silently. Only a dereference that falls outside the bounds is reported.

Top module: `cap_access_check`

## Requirements
- R1: The effective address is base + offset + scaled immediate + register operand, computed modulo 2^64. A wrap in this sum never raises a fault of its own, and an offset lying outside the bounds is allowed when the final address is inside them.
- R2: The 12-bit immediate is sign-extended and multiplied by the access width. For data kinds the width is 2^size_log2 bytes. For capability kinds it is always 16 bytes, and size_log2 is ignored.
- R3: The access covers the bytes from the effective address up to that address plus its width. If these bytes do not all lie within [base, base + length), computed without wrap, the cause is 4 (bounds). An access ending exactly at base + length is legal.
- R4: Any access through a capability whose tag is 0 gives cause 1 (tag).
- R5: Any access through a tagged, sealed capability gives cause 2 (seal).
- R6: Permission bits: bit 0 is load, bit 1 is store, bit 2 is load-capability, bit 3 is store-capability. Load kinds need bit 0 and store kinds need bit 1. A capability store of a tagged value also needs bit 3. If any of these is missing, the cause is 3 (permission).
- R7: A capability load returns tag_out = loaded tag AND permission bit 2 AND page_lcap. Missing either capability-load right never causes a fault.
- R8: A capability store of a tagged value to a page whose page_scap is 0 gives cause 5 (page store). An untagged capability store proceeds without fault and writes tag_out = 0.
- R9: When several conditions hold at once, the reported cause follows the priority tag > seal > permission > bounds > page store.
- R10: Outputs are registered. rsp_valid follows req_valid one cycle later. fault is 1 exactly when cause is nonzero. tag_out is 0 on a fault and on every data access. Reset clears rsp_valid, fault, cause, tag_out and ea to 0.
- R11: The kind is encoded 0 = data load, 1 = data store, 2 = capability load, 3 = capability store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability sealed flag |
| cap_base | input | 64 | Lower bound |
| cap_length | input | 64 | Length of the bounded region |
| cap_offset | input | 64 | Cursor offset from base |
| cap_perms | input | 4 | Permission bits (see R6) |
| imm | input | 12 | Signed immediate, unscaled |
| reg_op | input | 64 | Register operand added to the address |
| size_log2 | input | 2 | log2 of the data access width |
| kind | input | 2 | Access kind (see R11) |
| page_lcap | input | 1 | Page allows loading tags |
| page_scap | input | 1 | Page allows storing tags |
| mem_tag | input | 1 | Tag read from memory on a capability load |
| wr_tag | input | 1 | Tag of the value a capability store writes |
| rsp_valid | output | 1 | Response valid |
| ea | output | 64 | Effective address |
| fault | output | 1 | Access must trap |
| cause | output | 3 | Fault cause code (0 = none) |
| tag_out | output | 1 | Tag returned or written |

## Verification
A wrong bounds comparison or a wrong scale shift shows up at the ports on the very next cycle. It appears as a cause of 4 on an access that ends exactly at the top of the region, or as a missing fault on a one-byte overrun. A misordered priority shows up as the wrong nonzero cause when a vector breaks several rules at once. A wrong tag rule shows up as tag_out set after a load that lacked a capability-load right, or as a page-store fault on an untagged store. Because the block holds no state beyond one register stage, every such error appears exactly one cycle after the request that provokes it.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

  typedef enum logic [1:0] {
    ACC_LD  = 2'd0,
    ACC_ST  = 2'd1,
    ACC_CLD = 2'd2,
    ACC_CST = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CS_NONE   = 3'd0,
    CS_TAG    = 3'd1,
    CS_SEAL   = 3'd2,
    CS_PERM   = 3'd3,
    CS_BOUNDS = 3'd4,
    CS_PAGE   = 3'd5
  } cause_e;

  localparam int PB_LOAD  = 0;
  localparam int PB_STORE = 1;
  localparam int PB_LCAP  = 2;
  localparam int PB_SCAP  = 3;
  localparam int PERM_W   = 4;

  function automatic logic kind_is_cap(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_store(input logic [1:0] k);
    return k[0];
  endfunction

endpackage

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
  parameter int AW        = 64,
  parameter int IW        = 12,
  parameter int CAP_SHIFT = 4,
  parameter int SZW       = 2,
  localparam int SHW      = $clog2(CAP_SHIFT + 1)
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  offset,
  input  logic [IW-1:0]  imm,
  input  logic [AW-1:0]  reg_op,
  input  logic [SZW-1:0] size_log2,
  input  logic [1:0]     kind,
  output logic [AW-1:0]  ea,
  output logic [SHW-1:0] width_shift
);
  import cap_chk_pkg::*;

  function automatic logic [SHW-1:0] pick_shift(input logic [1:0] k,
                                                input logic [SZW-1:0] s);
    if (kind_is_cap(k)) return SHW'(CAP_SHIFT);
    return SHW'(s);
  endfunction

  function automatic logic [AW-1:0] scale_imm(input logic [IW-1:0] v,
                                              input logic [SHW-1:0] sh);
    logic [AW-1:0] ext;
    ext = {{(AW-IW){v[IW-1]}}, v};
    return ext << sh;
  endfunction

  logic [AW-1:0] imm_scaled;

  always_comb begin
    width_shift = pick_shift(kind, size_log2);
    imm_scaled  = scale_imm(imm, width_shift);
    ea          = base + offset + imm_scaled + reg_op;
  end

endmodule

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk #(
  parameter int AW  = 64,
  parameter int SHW = 3
) (
  input  logic [AW-1:0]  ea,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  length,
  input  logic [SHW-1:0] width_shift,
  output logic           in_bounds
);

  function automatic logic [AW:0] widen(input logic [AW-1:0] v);
    return {1'b0, v};
  endfunction

  logic [AW:0] acc_end;
  logic [AW:0] region_top;
  logic        low_ok;
  logic        high_ok;

  always_comb begin
    acc_end    = widen(ea) + ((AW+1)'(1) << width_shift);
    region_top = widen(base) + widen(length);
    low_ok     = ea >= base;
    high_ok    = acc_end <= region_top;
    in_bounds  = low_ok && high_ok;
  end

endmodule

// File: rtl/cap_fault_arb.sv
module cap_fault_arb
  import cap_chk_pkg::*;
#(
  parameter int PW = PERM_W
) (
  input  logic          cap_tag,
  input  logic          cap_sealed,
  input  logic [PW-1:0] cap_perms,
  input  logic [1:0]    kind,
  input  logic          in_bounds,
  input  logic          page_lcap,
  input  logic          page_scap,
  input  logic          mem_tag,
  input  logic          wr_tag,
  output logic [2:0]    cause,
  output logic          tag_result
);

  logic is_cap, is_st;
  logic perm_miss;
  logic page_block;
  logic cap_ld_keep;

  always_comb begin
    is_cap      = kind_is_cap(kind);
    is_st       = kind_is_store(kind);
    perm_miss   = is_st ? (!cap_perms[PB_STORE] ||
                           (is_cap && wr_tag && !cap_perms[PB_SCAP]))
                        : !cap_perms[PB_LOAD];
    page_block  = is_cap && is_st && wr_tag && !page_scap;
    cap_ld_keep = mem_tag && cap_perms[PB_LCAP] && page_lcap;

    if (!cap_tag)        cause = CS_TAG;
    else if (cap_sealed) cause = CS_SEAL;
    else if (perm_miss)  cause = CS_PERM;
    else if (!in_bounds) cause = CS_BOUNDS;
    else if (page_block) cause = CS_PAGE;
    else                 cause = CS_NONE;

    if (cause != CS_NONE || !is_cap) tag_result = 1'b0;
    else if (is_st)                  tag_result = wr_tag;
    else                             tag_result = cap_ld_keep;
  end

endmodule

// File: rtl/cap_access_check.sv
module cap_access_check #(
  parameter int AW        = 64,
  parameter int IW        = 12,
  parameter int CAP_SHIFT = 4,
  parameter int SZW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          cap_tag,
  input  logic          cap_sealed,
  input  logic [AW-1:0] cap_base,
  input  logic [AW-1:0] cap_length,
  input  logic [AW-1:0] cap_offset,
  input  logic [3:0]    cap_perms,
  input  logic [IW-1:0] imm,
  input  logic [AW-1:0] reg_op,
  input  logic [SZW-1:0] size_log2,
  input  logic [1:0]    kind,
  input  logic          page_lcap,
  input  logic          page_scap,
  input  logic          mem_tag,
  input  logic          wr_tag,
  output logic          rsp_valid,
  output logic [AW-1:0] ea,
  output logic          fault,
  output logic [2:0]    cause,
  output logic          tag_out
);
  import cap_chk_pkg::*;

  localparam int SHW = $clog2(CAP_SHIFT + 1);

  logic [AW-1:0]  ea_w;
  logic [SHW-1:0] shift_w;
  logic           in_bounds_w;
  logic [2:0]     cause_w;
  logic           tag_w;

  cap_addr_gen #(.AW(AW), .IW(IW), .CAP_SHIFT(CAP_SHIFT), .SZW(SZW)) u_addr (
    .base(cap_base), .offset(cap_offset), .imm(imm), .reg_op(reg_op),
    .size_log2(size_log2), .kind(kind), .ea(ea_w), .width_shift(shift_w)
  );

  cap_bounds_chk #(.AW(AW), .SHW(SHW)) u_bounds (
    .ea(ea_w), .base(cap_base), .length(cap_length),
    .width_shift(shift_w), .in_bounds(in_bounds_w)
  );

  cap_fault_arb #(.PW(4)) u_arb (
    .cap_tag(cap_tag), .cap_sealed(cap_sealed), .cap_perms(cap_perms),
    .kind(kind), .in_bounds(in_bounds_w), .page_lcap(page_lcap),
    .page_scap(page_scap), .mem_tag(mem_tag), .wr_tag(wr_tag),
    .cause(cause_w), .tag_result(tag_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      ea        <= '0;
      fault     <= 1'b0;
      cause     <= 3'd0;
      tag_out   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) ea <= ea_w;
      fault     <= req_valid && (cause_w != CS_NONE);
      cause     <= req_valid ? cause_w : 3'd0;
      tag_out   <= req_valid && tag_w;
    end
  end

  // Untagged capability always traps with the tag cause
  assert_untagged_traps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !cap_tag |=> fault && cause == CS_TAG);

  // Sealed, tagged capability traps with the seal cause
  assert_sealed_traps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cap_tag && cap_sealed |=> fault && cause == CS_SEAL);

  // Page without load-capability right never returns a tag
  assert_lcap_strips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && kind == ACC_CLD && !page_lcap |=> !tag_out && cause != CS_PAGE);

  // Untagged store never trips the page-store cause
  assert_untagged_store_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !wr_tag |=> cause != CS_PAGE);

  // A faulting response never carries a tag
  assert_fault_no_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !tag_out && cause != CS_NONE);

  // Response follows request by one cycle
  assert_resp_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_resp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !fault);

endmodule

// File: tb/cap_access_check_bench.sv
module cap_access_check_bench;

  localparam int PERIOD = 10;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  size;
    logic        tag;
    logic        sealed;
    logic [3:0]  perms;
    logic        lcap;
    logic        scap;
    logic        mtag;
    logic        wtag;
    logic [63:0] base;
    logic [63:0] len;
    logic [63:0] off;
    logic [11:0] imm;
    logic [63:0] rg;
    logic [2:0]  ecause;
    logic        etag;
  } vec_t;

  localparam int NV = 22;
  localparam logic [63:0] B  = 64'h1000;
  localparam logic [63:0] L  = 64'h100;
  localparam logic [63:0] HB = 64'hFFFF_FFFF_FFFF_FF00;

  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b1,1'b0,B,L,64'h0,12'h000,64'h0,3'd0,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,B,L,64'hF8,12'h000,64'h0,3'd0,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,B,L,64'hF9,12'h000,64'h0,3'd4,1'b0},
    '{2'd0,2'd0,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,B,L,64'h0,12'hFFF,64'h0,3'd4,1'b0},
    '{2'd1,2'd2,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,B,L,64'h0,12'h003,64'h0,3'd0,1'b0},
    '{2'd2,2'd0,1'b1,1'b0,4'hF,1'b1,1'b1,1'b1,1'b0,B,L,64'h0,12'h002,64'h0,3'd0,1'b1},
    '{2'd2,2'd0,1'b1,1'b0,4'hF,1'b0,1'b1,1'b1,1'b0,B,L,64'h0,12'h000,64'h0,3'd0,1'b0},
    '{2'd2,2'd0,1'b1,1'b0,4'hB,1'b1,1'b1,1'b1,1'b0,B,L,64'h0,12'h000,64'h0,3'd0,1'b0},
    '{2'd3,2'd0,1'b1,1'b0,4'hF,1'b1,1'b0,1'b0,1'b1,B,L,64'h0,12'h000,64'h0,3'd5,1'b0},
    '{2'd3,2'd0,1'b1,1'b0,4'hF,1'b1,1'b0,1'b0,1'b0,B,L,64'h0,12'h000,64'h0,3'd0,1'b0},
    '{2'd0,2'd3,1'b0,1'b1,4'hF,1'b1,1'b1,1'b0,1'b0,B,L,64'h0,12'h000,64'h0,3'd1,1'b0},
    '{2'd0,2'd3,1'b1,1'b1,4'h0,1'b1,1'b1,1'b0,1'b0,B,L,64'h0,12'h000,64'h0,3'd2,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'h0,1'b1,1'b1,1'b0,1'b0,B,L,64'h200,12'h000,64'h0,3'd3,1'b0},
    '{2'd1,2'd3,1'b1,1'b0,4'h1,1'b1,1'b1,1'b0,1'b0,B,L,64'h0,12'h000,64'h0,3'd3,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,HB,L,64'hF8,12'h000,64'h0,3'd0,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,HB,L,64'h100,12'h000,64'h10,3'd4,1'b0},
    '{2'd0,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b0,64'h2000,L,64'hFFFF_FFFF_FFFF_F000,12'h000,64'h1010,3'd0,1'b0},
    '{2'd3,2'd0,1'b1,1'b0,4'h7,1'b1,1'b1,1'b0,1'b1,B,L,64'h0,12'h000,64'h0,3'd3,1'b0},
    '{2'd3,2'd0,1'b1,1'b0,4'h7,1'b1,1'b0,1'b0,1'b1,B,L,64'h0,12'h000,64'h0,3'd3,1'b0},
    '{2'd2,2'd3,1'b1,1'b0,4'hF,1'b1,1'b1,1'b1,1'b0,B,L,64'hF0,12'h000,64'h0,3'd0,1'b1},
    '{2'd2,2'd0,1'b1,1'b0,4'hF,1'b1,1'b1,1'b1,1'b0,B,L,64'hF8,12'h000,64'h0,3'd4,1'b0},
    '{2'd3,2'd0,1'b1,1'b0,4'hF,1'b1,1'b1,1'b0,1'b1,B,L,64'h0,12'h000,64'h0,3'd0,1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic cap_tag = 1'b0, cap_sealed = 1'b0;
  logic [63:0] cap_base = '0, cap_length = '0, cap_offset = '0, reg_op = '0;
  logic [3:0]  cap_perms = '0;
  logic [11:0] imm = '0;
  logic [1:0]  size_log2 = '0, kind = '0;
  logic page_lcap = 1'b0, page_scap = 1'b0, mem_tag = 1'b0, wr_tag = 1'b0;
  logic rsp_valid, fault, tag_out;
  logic [63:0] ea;
  logic [2:0]  cause;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cap_access_check u_cap_access_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cap_tag(cap_tag),
    .cap_sealed(cap_sealed), .cap_base(cap_base), .cap_length(cap_length),
    .cap_offset(cap_offset), .cap_perms(cap_perms), .imm(imm), .reg_op(reg_op),
    .size_log2(size_log2), .kind(kind), .page_lcap(page_lcap),
    .page_scap(page_scap), .mem_tag(mem_tag), .wr_tag(wr_tag),
    .rsp_valid(rsp_valid), .ea(ea), .fault(fault), .cause(cause),
    .tag_out(tag_out)
  );

  // Bench's own restatement of the address rule (R1, R2)
  function automatic logic [63:0] expect_ea(input vec_t v);
    longint unsigned step;
    longint signed   sv;
    step = (v.kind >= 2'd2) ? 64'd16 : (64'd1 << v.size);
    sv   = longint'($signed(v.imm));
    return v.base + v.off + (64'(sv) * step) + v.rg;
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0, 16:          return "R1";
      4, 5:           return "R2";
      1, 2, 3, 14, 15, 19, 20: return "R3";
      10:             return "R4";
      11:             return "R5";
      13, 17:         return "R6";
      6, 7:           return "R7";
      8, 9, 21:       return "R8";
      default:        return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    kind = v.kind; size_log2 = v.size; cap_tag = v.tag; cap_sealed = v.sealed;
    cap_perms = v.perms; page_lcap = v.lcap; page_scap = v.scap;
    mem_tag = v.mtag; wr_tag = v.wtag; cap_base = v.base; cap_length = v.len;
    cap_offset = v.off; imm = v.imm; reg_op = v.rg; req_valid = 1'b1;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", {127'd0, rsp_valid}, 128'd0, "rsp_valid at reset");
    check("R10", {64'd0, ea, 1'b0, cause, fault, tag_out},
          128'd0, "outputs at reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      check(req_of(i), {64'd0, ea}, {64'd0, expect_ea(VECS[i])},
            $sformatf("ea vec %0d", i));
      check(req_of(i), {122'd0, rsp_valid, fault, cause, tag_out},
            {122'd0, 1'b1, (VECS[i].ecause != 3'd0), VECS[i].ecause,
             VECS[i].etag}, $sformatf("valid/fault/cause/tag vec %0d", i));
    end

    // R10: idle cycle clears valid and fault
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", {125'd0, rsp_valid, fault, tag_out}, 128'd0, "idle response");

    // R11 / R2: capability kind ignores size_log2 (16-byte scale)
    drive(VECS[5]);
    size_log2 = 2'd1;
    @(posedge clk);
    @(negedge clk);
    check("R11", {64'd0, ea}, {64'd0, 64'h1020}, "cap scale ignores size");

    // R10: mid-run reset clears outputs
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", {64'd0, ea, rsp_valid, cause, fault, tag_out}, 128'd0,
          "outputs after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule